// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block is the numerically controlled oscillator that sets the colour subcarrier phase for an analogue TV encoder. It runs on the core clock and advances only on a pixel-rate enable, which is one core clock in eight in normal use. On each such enable a 32-bit accumulator grows by twice the active frequency control word. This scaling means a word of 0x80000000 produces a subcarrier at exactly the pixel rate, so the output frequency is FCW / 2^31 × pixel rate. At every line start the accumulator is reloaded from an 8-bit start phase, where one step is 360/256 degrees. The whole phase word goes to a downstream chroma modulator, together with the top ten bits as an index into its sine table.

The active word depends on the standard select input. Each of the four quadrature-modulated standards has a built-in default word, which assumes a 13.5 MHz pixel rate. A programmed word, written as two 16-bit halves, replaces the default when a custom-enable bit is set. In SECAM mode the block holds two centre frequencies and swaps between them at every line start. One is the programmed word, used for the red-difference lines whatever the custom bit holds. The other comes from a separate word with its own reset value, used for the blue-difference lines.

Top module: `subcarrier_nco`

## Requirements
- R1: After a synchronous active-low reset, the phase output, the sine index and the SECAM line-select output are all 0. The programmed word resets to 0x29C71C72, the second SECAM word to 0x284BDA13, the start phase to 0 and the custom-enable bit to 0.
- R2: The programmed word is written as two halves: address 0 takes bits 31:16 and address 1 takes bits 15:0. A written half takes part in the first accumulator step after the write clock.
- R3: With the custom-enable bit clear, the standard select uses these default words: code 0 gives 0x21F07C1F, code 1 gives 0x2A098ACB, code 2 gives 0x21E6EFE3 and code 3 gives 0x21F69446. Codes 5, 6 and 7 fall back to the code-0 word.
- R4: On a clock where the pixel enable is high and line start is low, the accumulator gains two times the active word, modulo 2^32. The result appears on the phase output one clock later.
- R5: On a clock with line start high, the accumulator loads the start phase into bits 31:24 and zeros below them, and this takes precedence over the pixel enable.
- R6: With both pixel enable and line start low, the accumulator holds its value.
- R7: Writing address 5 sets the custom-enable bit from data bit 0. While it is set, any standard other than code 4 uses the programmed word instead of its default.
- R8: Standard code 4 selects SECAM. In this mode each line start inverts the line-select output. The active word is the programmed word while the output is 0 and the second SECAM word while it is 1, whatever the custom-enable bit holds.
- R9: When the standard select is not 4, the line-select output is 0 one clock later.
- R10: The phase output carries the full accumulator, and the sine index equals its bits 31:22.
- R11: Address 3 writes bits 31:16 of the second SECAM word and address 4 writes its bits 15:0. Address 2 writes the start phase from data bits 7:0, and the upper data bits are ignored there.
- R12: Over N consecutive steps that start from zero, the accumulator wraps floor(N × 2 × FCW / 2^32) times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-rate step enable |
| line_start | input | 1 | One-clock pulse at the start of each line |
| std_sel | input | 3 | Standard code (0 NTSC, 1 PAL, 2 PAL-M, 3 PAL-N, 4 SECAM) |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register address |
| wr_data | input | 16 | Configuration write data |
| phase_out | output | 32 | Accumulated subcarrier phase |
| sine_idx | output | 10 | Sine-table index for the modulator |
| db_sel | output | 1 | SECAM line select, 1 while the second centre word is active |

## Verification
The bench builds the block with its default parameters: a 32-bit word and accumulator, an 8-bit start phase and a 10-bit index. With these values every built-in standard word can be checked exactly, and the wrap from 0xFF000000 through zero happens within a single step. A window of 5000 PAL steps covers about 1650 wraps, and the wrap count is compared with the exact floor of N × 2 × FCW / 2^32. SECAM runs cover the swap between the two centre words and the clearing of the line select when the standard leaves SECAM.

// File: rtl/nco_pkg.sv
// Shared constants for the subcarrier oscillator: standard codes, the
// built-in control words at a 13.5 MHz pixel rate, register addresses
// and reset values. Assumes 32-bit control words.
package nco_pkg;

    typedef enum logic [2:0] {
        STD_NTSC  = 3'd0,
        STD_PAL   = 3'd1,
        STD_PAL_M = 3'd2,
        STD_PAL_N = 3'd3,
        STD_SECAM = 3'd4
    } tv_std_e;

    localparam logic [31:0] FCW_NTSC  = 32'h21F0_7C1F;
    localparam logic [31:0] FCW_PAL   = 32'h2A09_8ACB;
    localparam logic [31:0] FCW_PAL_M = 32'h21E6_EFE3;
    localparam logic [31:0] FCW_PAL_N = 32'h21F6_9446;
    localparam logic [31:0] PROG_RST  = 32'h29C7_1C72;
    localparam logic [31:0] ALT_RST   = 32'h284B_DA13;

    localparam logic [2:0] A_PROG_HI = 3'd0;
    localparam logic [2:0] A_PROG_LO = 3'd1;
    localparam logic [2:0] A_PHASE   = 3'd2;
    localparam logic [2:0] A_ALT_HI  = 3'd3;
    localparam logic [2:0] A_ALT_LO  = 3'd4;
    localparam logic [2:0] A_CTRL    = 3'd5;

    // Built-in word for a standard code; unknown codes fall back to NTSC.
    function automatic logic [31:0] std_default_fcw(input logic [2:0] code);
        case (code)
            STD_PAL:   return FCW_PAL;
            STD_PAL_M: return FCW_PAL_M;
            STD_PAL_N: return FCW_PAL_N;
            default:   return FCW_NTSC;
        endcase
    endfunction

    // Address of half-word slot i: 0 prog low, 1 prog high, 2 alt low, 3 alt high.
    function automatic logic [2:0] half_addr(input int i);
        case (i)
            0:       return A_PROG_LO;
            1:       return A_PROG_HI;
            2:       return A_ALT_LO;
            default: return A_ALT_HI;
        endcase
    endfunction

endpackage

// File: rtl/nco_cfg_regs.sv
// Configuration store: the programmed and alternate SECAM words as 16-bit
// halves, the start phase and the custom-enable bit. Writes land on the
// clock edge that samples wr_en. Assumes PHASE_W <= FCW_W/2.
module nco_cfg_regs
    import nco_pkg::*;
#(
    parameter int FCW_W   = 32,
    parameter int PHASE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [FCW_W/2-1:0]   wr_data,
    output logic [FCW_W-1:0]     prog_word,
    output logic [FCW_W-1:0]     alt_word,
    output logic [PHASE_W-1:0]   start_phase,
    output logic                 custom_en
);
    localparam int HALF_W = FCW_W / 2;
    localparam logic [2*FCW_W-1:0] RST_PAIR = {FCW_W'(ALT_RST), FCW_W'(PROG_RST)};

    logic [HALF_W-1:0] half_w [4];

    for (genvar g = 0; g < 4; g++) begin : g_half
        localparam logic [2:0] MY_ADDR = half_addr(g);
        logic [HALF_W-1:0] q;
        // Hold one half-word slot, loaded when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_PAIR[g*HALF_W +: HALF_W];
            else if (wr_en && wr_addr == MY_ADDR)
                q <= wr_data;
        end
        assign half_w[g] = q;
    end

    // Start phase and custom-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_phase <= '0;
            custom_en   <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_PHASE) start_phase <= wr_data[PHASE_W-1:0];
            if (wr_addr == A_CTRL)  custom_en   <= wr_data[0];
        end
    end

    assign prog_word = {half_w[1], half_w[0]};
    assign alt_word  = {half_w[3], half_w[2]};

    p_prog_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PROG_HI) |=> prog_word[FCW_W-1:HALF_W] == $past(wr_data));
    p_prog_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PROG_LO) |=> prog_word[HALF_W-1:0] == $past(wr_data));
    p_alt_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ALT_LO) |=> alt_word[HALF_W-1:0] == $past(wr_data));
    p_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PHASE) |=> start_phase == $past(wr_data[PHASE_W-1:0]));
endmodule

// File: rtl/nco_fcw_select.sv
// Picks the active control word from the standard code, custom-enable bit
// and, in SECAM, the line-alternating select flop kept here.
// Assumes line_start is a single-clock pulse.
module nco_fcw_select
    import nco_pkg::*;
#(
    parameter int FCW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       std_sel,
    input  logic             line_start,
    input  logic             custom_en,
    input  logic [FCW_W-1:0] prog_word,
    input  logic [FCW_W-1:0] alt_word,
    output logic [FCW_W-1:0] fcw,
    output logic             db_sel
);
    tv_std_e std;
    logic    is_secam;

    assign std      = tv_std_e'(std_sel);
    assign is_secam = (std == STD_SECAM);

    // Alternate the SECAM centre word per line; idle at 0 elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)
            db_sel <= 1'b0;
        else if (!is_secam)
            db_sel <= 1'b0;
        else if (line_start)
            db_sel <= ~db_sel;
    end

    // Select the word the accumulator steps by.
    always_comb begin
        if (is_secam)
            fcw = db_sel ? alt_word : prog_word;
        else if (custom_en)
            fcw = prog_word;
        else
            fcw = FCW_W'(std_default_fcw(std_sel));
    end

    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_secam && line_start) |=> db_sel != $past(db_sel));
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_secam |=> !db_sel);
endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator: adds twice the control word per pixel enable (so that
// 2^31 equals the pixel rate), reloads the start phase at line start, and
// presents the top bits as a sine index. Assumes ACC_W >= PHASE_W, IDX_W.
module nco_phase_acc #(
    parameter int FCW_W   = 32,
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 8,
    parameter int IDX_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic               line_start,
    input  logic [FCW_W-1:0]   fcw,
    input  logic [PHASE_W-1:0] start_phase,
    output logic [ACC_W-1:0]   acc_q,
    output logic [IDX_W-1:0]   idx
);
    localparam int LOW_W = ACC_W - PHASE_W;

    logic [ACC_W-1:0] step;
    assign step = ACC_W'({fcw, 1'b0});

    // Reload on line start, otherwise step on the pixel enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (line_start)
            acc_q <= {start_phase, {LOW_W{1'b0}}};
        else if (pix_en)
            acc_q <= acc_q + step;
    end

    assign idx = acc_q[ACC_W-1 -: IDX_W];

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !line_start) |=> (acc_q - $past(acc_q)) == ACC_W'({$past(fcw), 1'b0}));
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (acc_q[ACC_W-1 -: PHASE_W] == $past(start_phase)) && (acc_q[LOW_W-1:0] == '0));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !line_start) |=> $stable(acc_q));
endmodule

// File: rtl/subcarrier_nco.sv
// Top of the colour subcarrier oscillator: configuration store, word
// selection and phase accumulator. Assumes pix_en and line_start come
// from the same core clock domain.
module subcarrier_nco #(
    parameter int FCW_W   = 32,
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 8,
    parameter int IDX_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic               line_start,
    input  logic [2:0]         std_sel,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [FCW_W/2-1:0] wr_data,
    output logic [ACC_W-1:0]   phase_out,
    output logic [IDX_W-1:0]   sine_idx,
    output logic               db_sel
);
    logic [FCW_W-1:0]   prog_word;
    logic [FCW_W-1:0]   alt_word;
    logic [FCW_W-1:0]   fcw;
    logic [PHASE_W-1:0] start_phase;
    logic               custom_en;

    nco_cfg_regs #(.FCW_W(FCW_W), .PHASE_W(PHASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_word(prog_word), .alt_word(alt_word),
        .start_phase(start_phase), .custom_en(custom_en)
    );

    nco_fcw_select #(.FCW_W(FCW_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .line_start(line_start),
        .custom_en(custom_en), .prog_word(prog_word), .alt_word(alt_word),
        .fcw(fcw), .db_sel(db_sel)
    );

    nco_phase_acc #(.FCW_W(FCW_W), .ACC_W(ACC_W), .PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
        .fcw(fcw), .start_phase(start_phase), .acc_q(phase_out), .idx(sine_idx)
    );
endmodule

// File: tb/subcarrier_nco_tb.sv
// Scoreboard bench: the driver task computes the expected state from the
// requirements and queues it; the monitor pops and compares after each edge.
module subcarrier_nco_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, pix_en, line_start, wr_en;
    logic [2:0]  std_sel, wr_addr;
    logic [15:0] wr_data;
    logic [31:0] phase_out;
    logic [9:0]  sine_idx;
    logic        db_sel;

    subcarrier_nco u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
        .std_sel(std_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .phase_out(phase_out), .sine_idx(sine_idx), .db_sel(db_sel)
    );

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_acc = '0;
    logic        m_db = 1'b0;
    logic [15:0] m_hi = 16'h29C7, m_lo = 16'h1C72, m_ahi = 16'h284B, m_alo = 16'hDA13;
    logic [7:0]  m_ph = 8'h00;
    logic        m_cust = 1'b0;
    logic [2:0]  m_std = 3'd0;

    logic [31:0] q_acc[$];
    logic        q_db[$];
    string       q_req[$];

    bit          win_on = 1'b0;
    int          wraps = 0;
    logic [31:0] prev_acc = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dflt(input logic [2:0] c);
        case (c)
            3'd1:    return 32'h2A098ACB;
            3'd2:    return 32'h21E6EFE3;
            3'd3:    return 32'h21F69446;
            default: return 32'h21F07C1F;
        endcase
    endfunction

    // Drive one clock of stimulus and queue the expected result.
    task automatic cyc(input bit pix, input bit ls, input bit we,
                       input logic [2:0] a, input logic [15:0] d, input string req);
        logic [31:0] f;
        logic [31:0] nacc;
        logic        ndb;
        @(negedge clk);
        pix_en = pix; line_start = ls; wr_en = we; wr_addr = a; wr_data = d; std_sel = m_std;
        if (m_std == 3'd4)  f = m_db ? {m_ahi, m_alo} : {m_hi, m_lo};
        else if (m_cust)    f = {m_hi, m_lo};
        else                f = dflt(m_std);
        if (ls)       nacc = {m_ph, 24'h0};
        else if (pix) nacc = m_acc + {f[30:0], 1'b0};
        else          nacc = m_acc;
        if (m_std != 3'd4) ndb = 1'b0;
        else if (ls)       ndb = ~m_db;
        else               ndb = m_db;
        if (we) begin
            case (a)
                3'd0: m_hi = d;
                3'd1: m_lo = d;
                3'd2: m_ph = d[7:0];
                3'd3: m_ahi = d;
                3'd4: m_alo = d;
                3'd5: m_cust = d[0];
                default: ;
            endcase
        end
        m_acc = nacc;
        m_db = ndb;
        q_acc.push_back(nacc);
        q_db.push_back(ndb);
        q_req.push_back(req);
    endtask

    // Monitor: pop one expected item per clock and compare.
    always @(posedge clk) begin : mon
        logic [31:0] ea;
        logic        ed;
        string       r;
        #2;
        if (q_acc.size() > 0) begin
            ea = q_acc.pop_front();
            ed = q_db.pop_front();
            r  = q_req.pop_front();
            chk(r, phase_out, ea);
            chk("R10", {22'h0, sine_idx}, {22'h0, ea[31:22]});
            chk(r, {31'h0, db_sel}, {31'h0, ed});
            if (win_on && phase_out < prev_acc) wraps++;
            prev_acc = phase_out;
        end
    end

    initial begin : watchdog
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] exp_wraps;
        rst_n = 1'b0; pix_en = 1'b0; line_start = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; std_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1", phase_out, 32'h0);
        chk("R1", {22'h0, sine_idx}, 32'h0);
        chk("R1", {31'h0, db_sel}, 32'h0);

        // R1/R8: SECAM steps by the reset programmed word, then the reset alternate word
        m_std = 3'd4;
        cyc(1, 0, 0, 0, 0, "R1");
        cyc(1, 0, 0, 0, 0, "R4");
        cyc(0, 1, 0, 0, 0, "R8");
        cyc(1, 0, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, "R6");
        m_std = 3'd0;
        cyc(0, 0, 0, 0, 0, "R9");

        // R3: every non-SECAM code, including the fallback codes
        for (int s = 0; s < 8; s++) begin
            if (s != 4) begin
                m_std = 3'(s);
                cyc(0, 1, 0, 0, 0, "R5");
                cyc(1, 0, 0, 0, 0, "R3");
                cyc(1, 0, 0, 0, 0, "R3");
                cyc(1, 0, 0, 0, 0, "R3");
            end
        end

        // R2/R7: program a word; ignored until custom enable is set
        m_std = 3'd1;
        cyc(0, 0, 1, 3'd0, 16'h1234, "R2");
        cyc(1, 0, 1, 3'd1, 16'h5678, "R7");
        cyc(0, 1, 1, 3'd5, 16'h0001, "R7");
        cyc(1, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, "R7");

        // R8: SECAM uses the programmed word regardless of custom enable
        m_std = 3'd4;
        cyc(1, 0, 0, 0, 0, "R8");
        cyc(1, 0, 1, 3'd5, 16'h0000, "R8");
        cyc(1, 0, 0, 0, 0, "R8");

        // R11: rewrite the alternate SECAM word, then switch to it
        cyc(0, 0, 1, 3'd3, 16'hABCD, "R11");
        cyc(0, 1, 1, 3'd4, 16'h0123, "R11");
        cyc(1, 0, 0, 0, 0, "R11");
        cyc(1, 0, 0, 0, 0, "R11");

        // R5/R11: start phase from data low byte; load beats step
        cyc(0, 0, 1, 3'd2, 16'hFF28, "R11");
        cyc(0, 1, 0, 0, 0, "R5");
        cyc(1, 1, 0, 0, 0, "R5");

        // R4: wrap through zero from phase 0xFF
        m_std = 3'd0;
        cyc(0, 0, 1, 3'd2, 16'h00FF, "R9");
        cyc(0, 1, 0, 0, 0, "R5");
        cyc(1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 0, 0, "R4");

        // R12: wrap count over a long PAL window from zero
        m_std = 3'd1;
        cyc(0, 0, 1, 3'd2, 16'h0000, "R6");
        cyc(0, 1, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, "R6");
        @(negedge clk);
        win_on = 1'b1;
        wraps = 0;
        for (int i = 0; i < 5000; i++) cyc(1, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, 0, "R6");
        @(negedge clk);
        win_on = 1'b0;
        exp_wraps = (64'd5000 * 64'h54131596) >> 32;
        chk("R12", 32'(wraps), exp_wraps[31:0]);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule